// File: doc/BRIEF.md
# ADC power shutdown sequencer

This block supervises the low-power states of a sampling converter. An active-low shutdown input puts the converter to rest, and a mode-select line chooses how deep. With mode select high, the block enters a light nap: the reference stays powered and only the converter bias drops. With mode select low, it enters a deep sleep and both supplies are dropped. The depth is chosen at the clock edge that first sees the shutdown input low. Nap is granted only if mode select has already been high for a programmable number of edges. If that setup is too short, the block falls back to sleep.

When the shutdown input returns high, the block counts a wake-up delay before it marks itself ready again. A nap needs only a short delay. A sleep needs a delay that is orders of magnitude longer, because the reference must settle again. The ready flag gates conversion start requests. A request made while the block is not ready is dropped and raises a sticky error flag. The two enables drive the bias domain and the reference domain.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, ready, bias_en and ref_en are 1 and err is 0.
- R2: At the first clock edge that samples shdn_n low, ready and bias_en go to 0 and stay 0 while shdn_n stays low.
- R3: If nap_sel was sampled high at MODE_SETUP_CYC or more consecutive edges before the edge that first samples shdn_n low, the block enters nap: ref_en=1, bias_en=0.
- R4: If nap_sel is low, or was high for fewer than MODE_SETUP_CYC edges at that point, the block enters sleep: ref_en=0, bias_en=0.
- R5: Once the depth is chosen, changes on nap_sel during shutdown have no effect on ref_en or bias_en.
- R6: When waking from nap, bias_en and ref_en are 1 from the first edge that samples shdn_n high. ready rises NAP_WAKE_CYC edges after that edge.
- R7: When waking from sleep, ready rises SLEEP_WAKE_CYC edges after the first edge that samples shdn_n high.
- R8: If sleep was entered at any point since ready was last high, the wake-up uses the sleep delay, even when the latest shutdown chose nap.
- R9: While ready is 1, conv_go follows start_req in the same cycle. While ready is 0, conv_go is 0.
- R10: A start_req sampled while ready is 0 is dropped and sets err at that edge. err then stays 1 until reset.
- R11: shdn_n falling during a wake-up aborts it and enters the depth chosen anew. The next wake-up count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Shutdown request, active low |
| nap_sel | input | 1 | Depth select: 1 nap, 0 sleep |
| start_req | input | 1 | Conversion start request |
| conv_go | output | 1 | Start request passed on to the converter |
| ready | output | 1 | Converter may start a conversion |
| bias_en | output | 1 | Converter bias domain enable |
| ref_en | output | 1 | Reference domain enable |
| err | output | 1 | Sticky dropped-start error |

## Verification
The setup window is probed one edge short of the limit, exactly at it, and above it. A design with an off-by-one error in the setup counter would enter the wrong depth at the boundary. Wake-up latency is measured edge by edge for both depths. A counter that is one cycle early or late would show up there, and so would a design that picks the short delay after sleep. The most demanding cases are these: a wake-up interrupted by a nap request after an earlier sleep, which must still take the long delay, and an interrupted wake-up that must restart its count. Start requests during shutdown must produce no conv_go and must leave err set after the block has woken again.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int NAP_WAKE_CYC   = 40,
  parameter int SLEEP_WAKE_CYC = 2_000_000,
  parameter int MODE_SETUP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic nap_sel,
  input  logic start_req,
  output logic conv_go,
  output logic ready,
  output logic bias_en,
  output logic ref_en,
  output logic err
);
  localparam int CW = $clog2(SLEEP_WAKE_CYC + 1);
  localparam int SW = $clog2(MODE_SETUP_CYC + 1);

  typedef enum logic [1:0] {ST_RUN, ST_NAP, ST_SLP, ST_WAKE} st_t;

  st_t           st;
  logic [CW-1:0] wcnt;
  logic [SW-1:0] su;
  logic          deep;
  logic          nap_ok;
  logic [CW-1:0] lim;

  assign nap_ok  = nap_sel && (su == SW'(MODE_SETUP_CYC));
  assign lim     = deep ? CW'(SLEEP_WAKE_CYC) : CW'(NAP_WAKE_CYC);
  assign ready   = (st == ST_RUN);
  assign bias_en = (st == ST_RUN) || (st == ST_WAKE);
  assign ref_en  = (st != ST_SLP);
  assign conv_go = start_req && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_RUN;
      wcnt <= '0;
      su   <= '0;
      deep <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (!nap_sel)
        su <= '0;
      else if (su != SW'(MODE_SETUP_CYC))
        su <= su + 1'b1;

      if (start_req && !ready)
        err <= 1'b1;

      case (st)
        ST_RUN, ST_WAKE: begin
          if (!shdn_n) begin
            st <= nap_ok ? ST_NAP : ST_SLP;
            if (!nap_ok) deep <= 1'b1;
          end else if (st == ST_WAKE) begin
            if (wcnt == lim - 1'b1) begin
              st   <= ST_RUN;
              deep <= 1'b0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        default: begin
          if (shdn_n) begin
            st   <= ST_WAKE;
            wcnt <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int NAP_WAKE_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic shdn_n,
  input logic start_req,
  input logic conv_go,
  input logic ready,
  input logic bias_en,
  input logic ref_en,
  input logic err
);
  logic [31:0] wk;

  always_ff @(posedge clk) begin
    if (!rst_n || !shdn_n) wk <= '0;
    else if (!ready && wk != 32'hFFFF_FFFF) wk <= wk + 1;
  end

  AST_GO_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !conv_go); // R9
  AST_ERR_ON_DROP:    assert property (@(posedge clk) disable iff (!rst_n) (start_req && !ready) |=> err); // R10
  AST_ERR_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R10
  AST_SHDN_BLOCKS:    assert property (@(posedge clk) disable iff (!rst_n) !shdn_n |=> (!ready && !bias_en)); // R2
  AST_REF_COVERS:     assert property (@(posedge clk) disable iff (!rst_n) !ref_en |-> !bias_en); // R4
  AST_NAP_HELD:       assert property (@(posedge clk) disable iff (!rst_n) (!bias_en && ref_en && !shdn_n) |=> ref_en); // R5
  AST_SLEEP_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (!ref_en && !shdn_n) |=> !ref_en); // R5
  AST_WAKE_MIN:       assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> (wk >= 32'(NAP_WAKE_CYC))); // R6
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.NAP_WAKE_CYC(NAP_WAKE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .start_req(start_req),
  .conv_go(conv_go), .ready(ready), .bias_en(bias_en), .ref_en(ref_en), .err(err)
);

// File: tb/adc_pwr_seq_test.sv
`timescale 1ns/1ps
module adc_pwr_seq_test;
  localparam int NAP = 8;
  localparam int SLP = 200;
  localparam int SU  = 3;

  logic clk = 1'b0;
  logic rst_n, shdn_n, nap_sel, start_req;
  logic conv_go, ready, bias_en, ref_en, err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_pwr_seq #(.NAP_WAKE_CYC(NAP), .SLEEP_WAKE_CYC(SLP), .MODE_SETUP_CYC(SU)) uut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .nap_sel(nap_sel), .start_req(start_req),
    .conv_go(conv_go), .ready(ready), .bias_en(bias_en), .ref_en(ref_en), .err(err)
  );

  // {nap_sel level, edges held high before shutdown, expect nap}
  localparam int NV = 5;
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 4'd4, 1'b0},
    {1'b1, 4'd1, 1'b0},
    {1'b1, 4'd2, 1'b0},
    {1'b1, 4'd3, 1'b1},
    {1'b1, 4'd6, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wake(output int n);
    shdn_n = 1'b1;
    n = 0;
    do begin
      tick();
      n++;
    end while (!ready && n < 1000);
  endtask

  task automatic shut(bit lvl, int k);
    nap_sel = 1'b0;
    tick();
    nap_sel = lvl;
    repeat (k) tick();
    shdn_n = 1'b0;
    tick();
  endtask

  initial begin
    int n;
    rst_n = 1'b0; shdn_n = 1'b1; nap_sel = 1'b0; start_req = 1'b0;
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 ready", ready, 1);
    chk("R1 bias_en", bias_en, 1);
    chk("R1 ref_en", ref_en, 1);
    chk("R1 err", err, 0);

    start_req = 1'b1; #1;
    chk("R9 conv_go while ready", conv_go, 1);
    tick();
    chk("R9 no err when ready", err, 0);
    start_req = 1'b0; #1;
    chk("R9 conv_go idle", conv_go, 0);

    for (int i = 0; i < NV; i++) begin
      shut(VEC[i][5], int'(VEC[i][4:1]));
      chk(VEC[i][0] ? "R3 nap ref_en" : "R4 sleep ref_en", ref_en, int'(VEC[i][0]));
      chk("R2 bias_en off", bias_en, 0);
      chk("R2 ready off", ready, 0);
      shdn_n = 1'b1;
      tick();
      chk("R6 bias_en during wake", bias_en, 1);
      chk("R6 ref_en during wake", ref_en, 1);
      n = 1;
      while (!ready && n < 1000) begin tick(); n++; end
      chk(VEC[i][0] ? "R6 nap wake edges" : "R7 sleep wake edges", n, VEC[i][0] ? NAP + 1 : SLP + 1);
    end

    shut(1'b1, SU);
    nap_sel = 1'b0;
    repeat (6) tick();
    chk("R5 nap held", ref_en, 1);
    chk("R5 nap bias", bias_en, 0);
    wake(n);
    chk("R6 nap wake after sel change", n, NAP + 1);

    shut(1'b0, 0);
    nap_sel = 1'b1;
    repeat (6) tick();
    chk("R5 sleep held", ref_en, 0);
    wake(n);
    chk("R7 sleep wake", n, SLP + 1);

    shut(1'b0, 0);
    nap_sel = 1'b1;
    shdn_n = 1'b1;
    repeat (5) tick();
    shdn_n = 1'b0;
    tick();
    chk("R11 abort into nap ref_en", ref_en, 1);
    chk("R11 abort bias off", bias_en, 0);
    wake(n);
    chk("R8 deep wake after nap", n, SLP + 1);

    shut(1'b1, SU);
    shdn_n = 1'b1;
    repeat (4) tick();
    shdn_n = 1'b0;
    tick();
    chk("R11 abort ready", ready, 0);
    wake(n);
    chk("R11 count restarts", n, NAP + 1);

    shut(1'b1, SU);
    start_req = 1'b1; #1;
    chk("R10 dropped conv_go", conv_go, 0);
    tick();
    start_req = 1'b0;
    chk("R10 err set", err, 1);
    wake(n);
    chk("R10 err sticky", err, 1);
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 err cleared by reset", err, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule